// File: doc/BRIEF.md
# Pin Interrupt Controller Register Block

This block watches a vector of device pins and turns selected pin activity into one interrupt status line for a system interrupt controller. Each pin first passes through a polarity stage controlled by a per-pin invert bit. The result, called the sensed level, then goes through one of two per-pin sensing modes. In level mode a latch bit follows the sensed level. In edge mode a rising transition of the sensed level sets a sticky latch bit that software clears. A mask vector selects which latched pins raise a request, and the OR of all requests drives the interrupt output.

Software reaches the block through a simple 32-bit register port with byte addresses. The mask, edge-mode and invert vectors cannot be written directly. Each one has a set alias and a clear alias, and a write changes only the bits written as one. Both aliases read back the same vector, so software can update single pins without a read-modify-write and without racing other agents. A routing word (assign) is held for the neighbouring port multiplexer. Its reset value is a per-instance parameter. Pin inputs are assumed to be already synchronised to `clk`.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the mask, edge-mode, invert and latch vectors read 0, the assign word reads the parameter `ASSIGN_RST`, and `irq_out` is low.
- R2: Alias pairs sit at byte offsets mask 0x00 (set) / 0x04 (clear), edge-mode 0x10 / 0x14 and invert 0x18 / 0x1C. A set write ORs the written ones into the vector and a clear write removes them. Bits written as 0 change nothing, and both aliases of a pair read the current vector.
- R3: The assign word at 0x0C is a plain read/write register. The pin-state word at 0x20 is read-only: a write there is accepted without error and has no effect.
- R4: The sensed level of pin n is `pin_in[n]` XOR invert bit n, and a read of 0x20 returns the sensed levels of the current cycle.
- R5: In level mode (edge-mode bit 0) latch bit n equals the sensed level of the previous clock cycle, and writes to the latch cannot change it.
- R6: In edge mode (edge-mode bit 1) a 0-to-1 change of the sensed level between two cycles sets latch bit n, which then holds until a one is written to that bit at offset 0x24 (latch) or 0x08 (request). When a capture and a clear hit the same bit in the same cycle, the capture wins.
- R7: A read of offset 0x08 (request) returns latch AND mask. `irq_out` is high exactly when that AND is non-zero, in the same cycle.
- R8: An access with `bus_full` low, an address with bits [1:0] non-zero, or an offset above 0x24 sets `bus_err` for one cycle, returns read data 0 and changes no state.
- R9: `bus_rdata` and `bus_err` are registered. They carry the result in the cycle after the strobe, and `bus_rdata` is 0 in any cycle that follows no valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 6 | Byte offset inside the register window |
| bus_full | input | 1 | 1 = 32-bit access; 0 = narrower access, which is rejected |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_err | output | 1 | Access error pulse, one cycle after the strobe |
| pin_in | input | NUM_PINS | Synchronised pin levels |
| irq_out | output | 1 | Interrupt status toward the system interrupt controller |

## Verification
The bench walks every pin through both sensing modes and clears alternately through the latch and the request offsets. A design that cleared only through one offset would then leave a request pending, and one that wired a pin to the wrong latch bit would show a foreign bit. It flips an invert bit while the pin stays idle, which must count as a captured edge. It also lands a software clear and a fresh rising edge on the same bit in the same cycle, where a design that favoured the clear would lose an interrupt. Narrow, misaligned and out-of-window accesses are sent as both reads and writes. A decoder that checked only the offset would then corrupt the mask or return stale data. The alias sequences include writes of zero, which must leave each vector unchanged, and they compare both aliases of each pair.

// File: rtl/pint_pkg.sv
// Shared constants and the register index type for the pin interrupt controller.
// Assumes a 32-bit data port and byte addressing with 4-byte register stride.
package pint_pkg;
    localparam int DW       = 32;
    localparam int AW       = 6;
    localparam int IW       = AW - 2;
    localparam int NUM_REGS = 10;

    // Word index inside the window; the order fixes the byte offsets.
    typedef enum logic [IW-1:0] {
        IDX_MASK_SET = 4'd0,
        IDX_MASK_CLR = 4'd1,
        IDX_REQUEST  = 4'd2,
        IDX_ASSIGN   = 4'd3,
        IDX_EDGE_SET = 4'd4,
        IDX_EDGE_CLR = 4'd5,
        IDX_INV_SET  = 4'd6,
        IDX_INV_CLR  = 4'd7,
        IDX_PINSTATE = 4'd8,
        IDX_LATCH    = 4'd9
    } reg_idx_e;

    // True when the access is full width, word aligned and inside the window.
    function automatic logic access_ok(input logic [AW-1:0] addr, input logic full);
        return full && (addr[1:0] == 2'b00) && (addr[AW-1:2] < IW'(NUM_REGS));
    endfunction
endpackage

// File: rtl/pint_alias_vec.sv
// One state vector that is changed only through a set/clear alias pair.
// Assumes the caller has already qualified wr_ok with a legal access.
module pint_alias_vec
    import pint_pkg::*;
#(
    parameter int             NUM_PINS = 32,
    parameter logic [IW-1:0]  SET_IDX  = 4'd0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ok,
    input  logic [IW-1:0]       idx,
    input  logic [NUM_PINS-1:0] wbits,
    output logic [NUM_PINS-1:0] vec
);
    localparam logic [IW-1:0] CLR_IDX = SET_IDX + 4'd1;

    // Apply set (OR) or clear (AND-NOT) writes; zero bits leave the vector alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec <= '0;
        end else if (wr_ok && (idx == SET_IDX)) begin
            vec <= vec | wbits;
        end else if (wr_ok && (idx == CLR_IDX)) begin
            vec <= vec & ~wbits;
        end
    end
endmodule

// File: rtl/pint_regfile.sv
// Register decode, alias vectors, assign word and registered read port.
// Assumes one strobe per access; reads and writes are fully decoded.
module pint_regfile
    import pint_pkg::*;
#(
    parameter int             NUM_PINS   = 32,
    parameter logic [DW-1:0]  ASSIGN_RST = 32'h0202_0303
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_full,
    input  logic [DW-1:0]       bus_wdata,
    input  logic [NUM_PINS-1:0] latch_v,
    input  logic [NUM_PINS-1:0] lvl_v,
    output logic [NUM_PINS-1:0] mask_v,
    output logic [NUM_PINS-1:0] edge_v,
    output logic [NUM_PINS-1:0] inv_v,
    output logic [NUM_PINS-1:0] latch_clr,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_err
);
    localparam int NUM_PAIRS = 3;
    localparam logic [IW-1:0] PAIR_SET [NUM_PAIRS] = '{IDX_MASK_SET, IDX_EDGE_SET, IDX_INV_SET};

    logic                acc_ok;
    logic                wr_ok;
    logic                rd_ok;
    reg_idx_e            idx;
    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] pair_vec [NUM_PAIRS];
    logic [DW-1:0]       assign_r;
    logic [DW-1:0]       rd_mux;

    assign acc_ok = access_ok(bus_addr, bus_full);
    assign wr_ok  = bus_wr && acc_ok;
    assign rd_ok  = bus_rd && acc_ok;
    assign idx    = reg_idx_e'(bus_addr[AW-1:2]);
    assign wbits  = bus_wdata[NUM_PINS-1:0];

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pint_alias_vec #(
            .NUM_PINS (NUM_PINS),
            .SET_IDX  (PAIR_SET[p])
        ) i_vec (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_ok (wr_ok),
            .idx   (idx),
            .wbits (wbits),
            .vec   (pair_vec[p])
        );
    end

    assign mask_v = pair_vec[0];
    assign edge_v = pair_vec[1];
    assign inv_v  = pair_vec[2];

    // Write-one-to-clear pulse toward the latch from either clear offset.
    assign latch_clr = (wr_ok && (idx == IDX_REQUEST || idx == IDX_LATCH)) ? wbits : '0;

    // Hold the routing word for the neighbouring port multiplexer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assign_r <= ASSIGN_RST;
        end else if (wr_ok && (idx == IDX_ASSIGN)) begin
            assign_r <= bus_wdata;
        end
    end

    // Select the word addressed by the current read.
    always_comb begin
        unique case (idx)
            IDX_MASK_SET, IDX_MASK_CLR: rd_mux = DW'(mask_v);
            IDX_EDGE_SET, IDX_EDGE_CLR: rd_mux = DW'(edge_v);
            IDX_INV_SET,  IDX_INV_CLR:  rd_mux = DW'(inv_v);
            IDX_REQUEST:                rd_mux = DW'(latch_v & mask_v);
            IDX_ASSIGN:                 rd_mux = assign_r;
            IDX_PINSTATE:               rd_mux = DW'(lvl_v);
            IDX_LATCH:                  rd_mux = DW'(latch_v);
            default:                    rd_mux = '0;
        endcase
    end

    // Register read data and the access error flag one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_ok ? rd_mux : '0;
            bus_err   <= (bus_wr || bus_rd) && !acc_ok;
        end
    end
endmodule

// File: rtl/pint_sense.sv
// Per-pin polarity, level/edge sensing and latch.
// Assumes pin_in is synchronous to clk; a capture beats a clear in the same cycle.
module pint_sense #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] inv_v,
    input  logic [NUM_PINS-1:0] edge_v,
    input  logic [NUM_PINS-1:0] latch_clr,
    output logic [NUM_PINS-1:0] lvl_v,
    output logic [NUM_PINS-1:0] lvl_q_v,
    output logic [NUM_PINS-1:0] latch_v
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic lvl;
        logic lvl_q;
        logic latch;

        assign lvl = pin_in[n] ^ inv_v[n];

        // Keep last cycle's sensed level for rising-edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= lvl;
        end

        // Level mode tracks the sensed level; edge mode captures and holds.
        always_ff @(posedge clk) begin
            if (!rst_n)         latch <= 1'b0;
            else if (edge_v[n]) latch <= (latch & ~latch_clr[n]) | (lvl & ~lvl_q);
            else                latch <= lvl;
        end

        assign lvl_v[n]   = lvl;
        assign lvl_q_v[n] = lvl_q;
        assign latch_v[n] = latch;
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
// Pin interrupt controller: register window plus per-pin sensing, one interrupt out.
// Assumes synchronised pins and a single-cycle strobe register port.
module pin_irq_ctrl
    import pint_pkg::*;
#(
    parameter int             NUM_PINS   = 32,
    parameter logic [DW-1:0]  ASSIGN_RST = 32'h0202_0303
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_full,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                bus_err,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] mask_v;
    logic [NUM_PINS-1:0] edge_v;
    logic [NUM_PINS-1:0] inv_v;
    logic [NUM_PINS-1:0] latch_v;
    logic [NUM_PINS-1:0] latch_clr;
    logic [NUM_PINS-1:0] lvl_v;
    logic [NUM_PINS-1:0] lvl_q_v;

    pint_regfile #(
        .NUM_PINS   (NUM_PINS),
        .ASSIGN_RST (ASSIGN_RST)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_full  (bus_full),
        .bus_wdata (bus_wdata),
        .latch_v   (latch_v),
        .lvl_v     (lvl_v),
        .mask_v    (mask_v),
        .edge_v    (edge_v),
        .inv_v     (inv_v),
        .latch_clr (latch_clr),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    pint_sense #(
        .NUM_PINS (NUM_PINS)
    ) i_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .inv_v     (inv_v),
        .edge_v    (edge_v),
        .latch_clr (latch_clr),
        .lvl_v     (lvl_v),
        .lvl_q_v   (lvl_q_v),
        .latch_v   (latch_v)
    );

    // Interrupt is raised by any latched pin that is unmasked.
    assign irq_out = |(latch_v & mask_v);
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
// Temporal checks on the pin interrupt controller, bound into the top module.
// Assumes byte offsets 0x00 / 0x04 for the mask alias pair.
module pin_irq_ctrl_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [5:0]          bus_addr,
    input logic                bus_full,
    input logic [31:0]         bus_wdata,
    input logic                bus_err,
    input logic [NUM_PINS-1:0] mask_v,
    input logic [NUM_PINS-1:0] edge_v,
    input logic [NUM_PINS-1:0] inv_v,
    input logic [NUM_PINS-1:0] latch_v,
    input logic [NUM_PINS-1:0] lvl_v,
    input logic [NUM_PINS-1:0] lvl_q_v
);
    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_full && bus_addr == 6'h00)
        |=> mask_v == ($past(mask_v) | $past(bus_wdata[NUM_PINS-1:0])));

    p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_full && bus_addr == 6'h04)
        |=> mask_v == ($past(mask_v) & ~$past(bus_wdata[NUM_PINS-1:0])));

    p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_v & ~$past(edge_v)) == ($past(lvl_v) & ~$past(edge_v))));

    p_edge_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_v & lvl_v & ~lvl_q_v) != '0)
        |=> ((latch_v & $past(edge_v & lvl_v & ~lvl_q_v)) == $past(edge_v & lvl_v & ~lvl_q_v)));

    p_narrow_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_full) |=> bus_err);

    p_bad_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_full) |=> ($stable(mask_v) && $stable(edge_v) && $stable(inv_v)));
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_full  (bus_full),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .mask_v    (mask_v),
    .edge_v    (edge_v),
    .inv_v     (inv_v),
    .latch_v   (latch_v),
    .lvl_v     (lvl_v),
    .lvl_q_v   (lvl_q_v)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
    localparam logic [31:0] ASSIGN_RST = 32'h0202_0303;
    localparam logic [5:0] A_MSET = 6'h00, A_MCLR = 6'h04, A_REQ = 6'h08, A_ASG = 6'h0C,
                           A_ESET = 6'h10, A_ECLR = 6'h14, A_ISET = 6'h18, A_ICLR = 6'h1C,
                           A_PINS = 6'h20, A_LAT = 6'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_full = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] pin_in = '0;
    logic        irq_out;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] rv;
    logic        last_err;

    always #4 clk = ~clk;

    pin_irq_ctrl #(.NUM_PINS(32), .ASSIGN_RST(ASSIGN_RST)) i_pin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_full(bus_full), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .pin_in(pin_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic full = 1'b1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_full = full;
        @(posedge clk); #1;
        last_err = bus_err;
        bus_wr = 1'b0; bus_full = 1'b1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, input logic full = 1'b1);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_full = full;
        @(posedge clk); #1;
        d = bus_rdata; last_err = bus_err;
        bus_rd = 1'b0; bus_full = 1'b1;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        @(posedge clk); #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        rd(A_MSET, rv); chk("R1 mask", rv, 0);
        rd(A_ECLR, rv); chk("R1 edge", rv, 0);
        rd(A_ISET, rv); chk("R1 invert", rv, 0);
        rd(A_LAT, rv);  chk("R1 latch", rv, 0);
        rd(A_ASG, rv);  chk("R1 assign", rv, ASSIGN_RST);
        chk("R1 irq", {31'b0, irq_out}, 0);
        // R9: no read in this cycle -> zero data
        tick(); chk("R9 idle rdata", bus_rdata, 0);

        // R2: alias pairs
        for (int p = 0; p < 3; p++) begin
            logic [5:0] s;
            s = (p == 0) ? A_MSET : (p == 1) ? A_ESET : A_ISET;
            exp = 32'hA5A5_0F0F;
            wr(s, exp);
            rd(s, rv);     chk("R2 set alias", rv, exp);
            rd(s + 6'h4, rv); chk("R2 clear alias readback", rv, exp);
            wr(s, 32'h0000_F000); exp |= 32'h0000_F000;
            rd(s + 6'h4, rv); chk("R2 set OR", rv, exp);
            wr(s + 6'h4, 32'h8000_000F); exp &= ~32'h8000_000F;
            rd(s, rv);     chk("R2 clear", rv, exp);
            wr(s, 32'h0); wr(s + 6'h4, 32'h0);
            rd(s, rv);     chk("R2 zero write", rv, exp);
            wr(s + 6'h4, 32'hFFFF_FFFF);
            rd(s, rv);     chk("R2 clear all", rv, 0);
        end

        // R4, R5: level mode, walking pin and patterns, with and without invert
        for (int i = 0; i < 34; i++) begin
            logic [31:0] pv;
            pv = (i < 32) ? (32'h1 << i) : (i == 32 ? 32'hDEAD_BEEF : 32'h0);
            set_pins(pv);
            rd(A_PINS, rv); chk("R4 pinstate", rv, pv);
            rd(A_LAT, rv);  chk("R5 level latch", rv, pv);
        end
        wr(A_ISET, 32'h0F0F_00FF);
        set_pins(32'h1234_5678);
        rd(A_PINS, rv); chk("R4 inverted pinstate", rv, 32'h1234_5678 ^ 32'h0F0F_00FF);
        rd(A_LAT, rv);  chk("R5 inverted latch", rv, 32'h1234_5678 ^ 32'h0F0F_00FF);
        wr(A_LAT, 32'hFFFF_FFFF);
        rd(A_LAT, rv);  chk("R5 level latch ignores clear", rv, 32'h1234_5678 ^ 32'h0F0F_00FF);
        wr(A_ICLR, 32'hFFFF_FFFF);

        // R7: request and interrupt
        wr(A_MSET, 32'h00FF_00F0);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pv;
            pv = (k == 0) ? 32'hFF00_FF0F : (k == 1) ? 32'h0001_0000 :
                 (k == 2) ? 32'h0000_0010 : 32'hFFFF_FFFF;
            set_pins(pv);
            chk("R7 irq", {31'b0, irq_out}, {31'b0, |(pv & 32'h00FF_00F0)});
            rd(A_REQ, rv); chk("R7 request", rv, pv & 32'h00FF_00F0);
        end
        wr(A_MCLR, 32'hFFFF_FFFF); tick();
        chk("R7 irq masked", {31'b0, irq_out}, 0);
        set_pins(32'h0);

        // R3: assign and pin-state
        wr(A_ASG, 32'h1234_5678);
        rd(A_ASG, rv); chk("R3 assign rw", rv, 32'h1234_5678);
        set_pins(32'h00C0_0003);
        wr(A_PINS, 32'hFFFF_FFFF); chk("R3 pinstate write no err", {31'b0, last_err}, 0);
        rd(A_PINS, rv); chk("R3 pinstate write ignored", rv, 32'h00C0_0003);
        set_pins(32'h0);

        // R8, R9: access errors
        wr(A_MSET, 32'hFFFF_FFFF, 1'b0); chk("R8 narrow write err", {31'b0, last_err}, 1);
        rd(A_MSET, rv, 1'b0); chk("R8 narrow read err", {31'b0, last_err}, 1);
        chk("R8 narrow read data", rv, 0);
        rd(A_MSET, rv); chk("R8 narrow write no effect", rv, 0);
        for (int k = 0; k < 4; k++) begin
            logic [5:0] ba;
            ba = (k == 0) ? 6'h28 : (k == 1) ? 6'h3C : (k == 2) ? 6'h02 : 6'h11;
            wr(ba, 32'hFFFF_FFFF); chk("R8 bad offset write err", {31'b0, last_err}, 1);
            rd(ba, rv); chk("R8 bad offset read err", {31'b0, last_err}, 1);
            chk("R8 bad offset read data", rv, 0);
        end
        rd(A_ESET, rv); chk("R8 no state change", rv, 0);
        for (int k = 0; k < 10; k++) begin
            rd(6'(k * 4), rv); chk("R8 legal offset no err", {31'b0, last_err}, 0);
        end
        tick(); chk("R9 rdata cleared after read", bus_rdata, 0);

        // R6: edge mode
        wr(A_ESET, 32'hFFFF_FFFF);
        wr(A_MSET, 32'hFFFF_FFFF);
        tick();
        wr(A_LAT, 32'hFFFF_FFFF);
        rd(A_LAT, rv); chk("R6 cleared start", rv, 0);
        for (int i = 0; i < 32; i++) begin
            set_pins(32'h1 << i);
            set_pins(32'h0);
            rd(A_LAT, rv); chk("R6 captured and held", rv, 32'h1 << i);
            chk("R6 irq from edge", {31'b0, irq_out}, 1);
            wr((i % 2 == 0) ? A_LAT : A_REQ, 32'h1 << i);
            rd(A_LAT, rv); chk("R6 w1c", rv, 0);
        end
        // invert flip on idle pin counts as a rising sensed edge
        wr(A_ISET, 32'h0000_0020); tick();
        rd(A_LAT, rv); chk("R6 invert edge", rv, 32'h0000_0020);
        wr(A_ICLR, 32'h0000_0020); tick();
        rd(A_LAT, rv); chk("R6 falling not captured", rv, 32'h0000_0020);
        wr(A_LAT, 32'h0000_0020);
        // capture and clear of the same bit in the same cycle
        @(negedge clk);
        pin_in = 32'h8; bus_wr = 1'b1; bus_addr = A_LAT; bus_wdata = 32'h8;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        rd(A_LAT, rv); chk("R6 capture beats clear", rv, 32'h8);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule